// File: doc/BRIEF.md
# Adaptive Clock Frequency Controller

This block recovers a line clock rate from how full a receive buffer is. A periodic update strobe presents a count of buffered frames. The block subtracts a programmable fill target from that count to form a signed error, and multiplies the error by a programmable loop gain. It clamps the product to a programmable symmetric limit and smooths it with a first-order exponential averager. The time constant of the averager is a programmable power of two, chosen longer than the cell arrival jitter so that short bursts do not move the rate.

The smoothed correction is added to a nominal frequency word. The sum drives a 32-bit phase accumulator, and the accumulator's top bit is the recovered clock. Because one accumulator step is 2^-32 of the system clock, a correction of a few units produces a very small rate change. While the buffer reports an underrun, the loop is bypassed and the nominal rate is used. The averager is held at zero during the underrun, so the loop restarts from the nominal rate with no step when the underrun ends.

Top module: `adaptive_rate_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `freq_word`, `corr_out` and `line_clk` are all zero.
- R2: On a cycle with `frame_tick` high, the loop input is (`fill_count` − `fill_target`), taken as a signed difference of two unsigned values, times the unsigned `loop_gain`.
- R3: Before filtering, the loop input is clamped to the range −`corr_limit` to +`corr_limit`. While the limit is unchanged, `corr_out` never leaves that range.
- R4: On a ticked edge without underrun, the averager does corr ← corr + floor((x − corr) / 2^K), where x is the clamped input. `corr_out` shows the new value after that edge.
- R5: The effective shift K is `lpf_shift` clamped to the range 4 to 16. A setting below 4 acts as 4, and a setting above 16 acts as 16.
- R6: One edge after `corr_out` changes, `freq_word` equals `nominal_word` + `corr_out`, saturated to the range 0 to 2^32−1 so that it never wraps.
- R7: On an edge with `frame_tick` low and `underrun` low, `corr_out` keeps its value, whatever happens at the fill and gain inputs.
- R8: On an edge with `underrun` high, `corr_out` becomes 0 and `freq_word` becomes `nominal_word`. After the underrun ends, the next tick updates the averager starting from 0.
- R9: `line_clk` is bit 31 of a 32-bit accumulator that adds `freq_word` on every clock. A constant word W therefore gives a period of 2^32/W clocks. For example, 2^28 gives 16 clocks and 2^29 gives 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle update strobe |
| fill_count | input | 12 | Measured buffer fill, in frames |
| fill_target | input | 12 | Nominal buffer fill |
| loop_gain | input | 8 | Unsigned error multiplier |
| lpf_shift | input | 5 | Averager shift K, clamped to 4..16 |
| corr_limit | input | 23 | Symmetric clamp on the loop input |
| nominal_word | input | 32 | Nominal phase increment |
| underrun | input | 1 | Forces the nominal rate and clears the averager |
| corr_out | output | 24 | Signed smoothed correction |
| freq_word | output | 32 | Phase increment in use |
| line_clk | output | 1 | Recovered clock, accumulator MSB |

## Verification
The loop is driven with repeated positive errors, negative errors and zero error. Together these show that the sign and scale of the subtraction and gain are right, and that the averager converges in steps that follow floor rounding. An error far above the limit, applied many times, separates the clamp from the filter. Shift settings of 0 and 31 from a cleared state tell the clamped shift apart from a raw one. Nominal words near 2^32 and near zero, paired with a correction of the opposite sign, test saturation at each end.

The remaining patterns target the hold, the override and the output rate. Changing the inputs without a tick tests the hold. An underrun that arrives together with a large error tests the override and the restart. Constant words of 2^28 and 2^29 are counted as edges of the recovered clock to test the accumulator rate.

// File: rtl/arc_pkg.sv
package arc_pkg;

   typedef enum logic [0:0] {
      ARC_OUT_SQUARE = 1'b0,
      ARC_OUT_PULSE  = 1'b1
   } arc_out_mode_e;

   localparam int ARC_KMIN = 4;
   localparam int ARC_KMAX = 16;

endpackage

// File: rtl/arc_err_scale.sv
module arc_err_scale #(
   parameter int FDW = 12,
   parameter int GW  = 8,
   parameter int CW  = 24
) (
   input  logic [FDW-1:0]       fill_count,
   input  logic [FDW-1:0]       fill_target,
   input  logic [GW-1:0]        loop_gain,
   input  logic [CW-2:0]        corr_limit,
   output logic signed [CW-1:0] x_clamped
);
   localparam int EW = FDW + 1;
   localparam int PW = EW + GW + 1;

   logic signed [EW-1:0] err;
   logic signed [PW-1:0] prod;
   logic signed [CW-1:0] wide;
   logic signed [CW-1:0] lim_pos;
   logic signed [CW-1:0] lim_neg;

   assign err     = $signed({1'b0, fill_count}) - $signed({1'b0, fill_target});
   assign prod    = PW'(err) * $signed({1'b0, loop_gain});
   assign wide    = CW'(prod);
   assign lim_pos = $signed({1'b0, corr_limit});
   assign lim_neg = -lim_pos;

   always_comb begin
      if (wide > lim_pos)
         x_clamped = lim_pos;
      else if (wide < lim_neg)
         x_clamped = lim_neg;
      else
         x_clamped = wide;
   end
endmodule

// File: rtl/arc_lowpass.sv
module arc_lowpass #(
   parameter int CW   = 24,
   parameter int KW   = 5,
   parameter int KMIN = arc_pkg::ARC_KMIN,
   parameter int KMAX = arc_pkg::ARC_KMAX
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic                 clear,
   input  logic [KW-1:0]        shift_req,
   input  logic signed [CW-1:0] x_in,
   output logic signed [CW-1:0] y_out
);
   logic [KW-1:0]        k_eff;
   logic signed [CW:0]   diff;
   logic signed [CW:0]   delta;
   logic signed [CW-1:0] y_q;
   logic signed [CW-1:0] y_next;

   always_comb begin
      if (shift_req < KW'(KMIN))
         k_eff = KW'(KMIN);
      else if (shift_req > KW'(KMAX))
         k_eff = KW'(KMAX);
      else
         k_eff = shift_req;
   end

   assign diff   = $signed({x_in[CW-1], x_in}) - $signed({y_q[CW-1], y_q});
   assign delta  = diff >>> k_eff;
   assign y_next = y_q + delta[CW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         y_q <= '0;
      else if (clear)
         y_q <= '0;
      else if (upd)
         y_q <= y_next;
   end

   assign y_out = y_q;
endmodule

// File: rtl/arc_phase_acc.sv
module arc_phase_acc #(
   parameter int                    AW       = 32,
   parameter arc_pkg::arc_out_mode_e OUT_MODE = arc_pkg::ARC_OUT_SQUARE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] step,
   output logic          tick_out
);
   logic [AW-1:0] acc_q;
   logic [AW:0]   acc_sum;

   assign acc_sum = {1'b0, acc_q} + {1'b0, step};

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else
         acc_q <= acc_sum[AW-1:0];
   end

   generate
      if (OUT_MODE == arc_pkg::ARC_OUT_SQUARE) begin : g_square
         assign tick_out = acc_q[AW-1];
      end else begin : g_pulse
         logic carry_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               carry_q <= 1'b0;
            else
               carry_q <= acc_sum[AW];
         end
         assign tick_out = carry_q;
      end
   endgenerate
endmodule

// File: rtl/adaptive_rate_ctrl.sv
module adaptive_rate_ctrl #(
   parameter int                    FDW      = 12,
   parameter int                    GW       = 8,
   parameter int                    CW       = 24,
   parameter int                    KW       = 5,
   parameter int                    AW       = 32,
   parameter arc_pkg::arc_out_mode_e OUT_MODE = arc_pkg::ARC_OUT_SQUARE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_tick,
   input  logic [FDW-1:0]       fill_count,
   input  logic [FDW-1:0]       fill_target,
   input  logic [GW-1:0]        loop_gain,
   input  logic [KW-1:0]        lpf_shift,
   input  logic [CW-2:0]        corr_limit,
   input  logic [AW-1:0]        nominal_word,
   input  logic                 underrun,
   output logic signed [CW-1:0] corr_out,
   output logic [AW-1:0]        freq_word,
   output logic                 line_clk
);
   localparam int PW = FDW + GW + 2;
   localparam int SW = AW + 2;

   if (CW < PW) begin : g_bad_cw
      $error("CW too narrow for error times gain");
   end
   if (CW > AW) begin : g_bad_aw
      $error("CW must not exceed AW");
   end
   if (arc_pkg::ARC_KMAX >= (1 << KW)) begin : g_bad_kw
      $error("KW cannot hold the largest shift");
   end

   logic signed [CW-1:0] x_clamped;
   logic signed [CW-1:0] y_val;
   logic signed [SW-1:0] sum;
   logic [AW-1:0]        fw_next;
   logic [AW-1:0]        fw_q;

   arc_err_scale #(.FDW(FDW), .GW(GW), .CW(CW)) u_err (
      .fill_count (fill_count),
      .fill_target(fill_target),
      .loop_gain  (loop_gain),
      .corr_limit (corr_limit),
      .x_clamped  (x_clamped)
   );

   arc_lowpass #(.CW(CW), .KW(KW)) u_lpf (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (frame_tick),
      .clear    (underrun),
      .shift_req(lpf_shift),
      .x_in     (x_clamped),
      .y_out    (y_val)
   );

   assign sum = $signed({2'b00, nominal_word}) + SW'(y_val);

   always_comb begin
      if (sum < 0)
         fw_next = '0;
      else if (sum[SW-1:AW] != '0)
         fw_next = '1;
      else
         fw_next = sum[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         fw_q <= '0;
      else if (underrun)
         fw_q <= nominal_word;
      else
         fw_q <= fw_next;
   end

   arc_phase_acc #(.AW(AW), .OUT_MODE(OUT_MODE)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (fw_q),
      .tick_out(line_clk)
   );

   assign corr_out  = y_val;
   assign freq_word = fw_q;
endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
   parameter int CW = 24,
   parameter int AW = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 frame_tick,
   input logic                 underrun,
   input logic [CW-2:0]        corr_limit,
   input logic [AW-1:0]        nominal_word,
   input logic signed [CW-1:0] corr_out,
   input logic [AW-1:0]        freq_word
);
   function automatic logic [AW-1:0] sat_word(input logic [AW-1:0] n,
                                              input logic signed [CW-1:0] c);
      logic signed [AW+1:0] s;
      s = $signed({2'b00, n}) + (AW+2)'(c);
      if (s < 0) return '0;
      if (s[AW+1:AW] != 2'b00) return '1;
      return s[AW-1:0];
   endfunction

   logic in_range;
   assign in_range = (corr_out <= $signed({1'b0, corr_limit})) &&
                     (corr_out >= -$signed({1'b0, corr_limit}));

   assert_clamp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_range |=> (corr_limit != $past(corr_limit)) || in_range);

   assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !underrun) |=> $stable(corr_out));

   assert_underrun_nominal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> (corr_out == '0) && (freq_word == $past(nominal_word)));

   assert_word_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !underrun |=> freq_word == sat_word($past(nominal_word), $past(corr_out)));
endmodule

bind adaptive_rate_ctrl arc_checker #(.CW(CW), .AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_tick  (frame_tick),
   .underrun    (underrun),
   .corr_limit  (corr_limit),
   .nominal_word(nominal_word),
   .corr_out    (corr_out),
   .freq_word   (freq_word)
);

// File: tb/sim_adaptive_rate_ctrl.sv
`timescale 1ns/1ps
module sim_adaptive_rate_ctrl;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               frame_tick = 1'b0;
   logic [11:0]        fill_count = '0;
   logic [11:0]        fill_target = '0;
   logic [7:0]         loop_gain = '0;
   logic [4:0]         lpf_shift = 5'd4;
   logic [22:0]        corr_limit = '0;
   logic [31:0]        nominal_word = '0;
   logic               underrun = 1'b0;
   logic signed [23:0] corr_out;
   logic [31:0]        freq_word;
   logic               line_clk;

   always #4 clk = ~clk;

   adaptive_rate_ctrl u0 (.*);

   typedef struct {
      longint fw;
      longint corr;
      string  req;
   } exp_t;

   exp_t   sb_q[$];
   event   chk_ev;
   int     n_chk = 0;
   int     n_fail = 0;
   longint m_y = 0;
   bit     done = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(chk_ev) begin
      exp_t it;
      it = sb_q.pop_front();
      check(longint'(corr_out) == it.corr, {it.req, " corr"}, longint'(corr_out), it.corr);
      check(longint'(freq_word) == it.fw, {it.req, " freq"}, longint'(freq_word), it.fw);
   end

   function automatic longint sat32(input longint v);
      if (v < 0) return 0;
      if (v > 64'hFFFF_FFFF) return 64'hFFFF_FFFF;
      return v;
   endfunction

   task automatic do_tick(input int fd, input int nd, input int g, input int k,
                          input longint lim, input longint nom, input bit ur, input string req);
      exp_t it;
      longint x;
      int ke;
      @(negedge clk);
      fill_count = 12'(fd); fill_target = 12'(nd); loop_gain = 8'(g);
      lpf_shift = 5'(k); corr_limit = 23'(lim); nominal_word = 32'(nom);
      underrun = ur; frame_tick = 1'b1;
      if (ur) begin
         m_y = 0;
         it.fw = nom;
      end else begin
         x = longint'(fd - nd) * g;
         if (x > lim) x = lim;
         if (x < -lim) x = -lim;
         ke = (k < 4) ? 4 : (k > 16) ? 16 : k;
         m_y = m_y + ((x - m_y) >>> ke);
         it.fw = sat32(nom + m_y);
      end
      it.corr = m_y;
      it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
      frame_tick = 1'b0;
      @(negedge clk);
      -> chk_ev;
      #1;
   endtask

   task automatic count_rises(input longint w, input int exp_n, input string req);
      int rises = 0;
      logic prev;
      @(negedge clk);
      underrun = 1'b1; nominal_word = 32'(w);
      repeat (4) @(negedge clk);
      prev = line_clk;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (line_clk && !prev) rises++;
         prev = line_clk;
      end
      check(rises == exp_n, req, rises, exp_n);
      underrun = 1'b0;
      m_y = 0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(freq_word == 0, "R1 freq", freq_word, 0);
      check(corr_out == 0, "R1 corr", corr_out, 0);
      check(line_clk == 0, "R1 clk", line_clk, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(freq_word == 0 && corr_out == 0, "R1 after", freq_word, 0);

      // R2 R4: positive error, several ticks
      for (int i = 0; i < 6; i++)
         do_tick(105, 100, 4, 4, 1000, 64'h1000_0000, 0, "R2 R4 pos");
      // R2 R4: negative error
      for (int i = 0; i < 6; i++)
         do_tick(90, 100, 3, 4, 1000, 64'h1000_0000, 0, "R2 R4 neg");
      // R4: zero error
      do_tick(100, 100, 200, 4, 1000, 64'h1000_0000, 0, "R4 zero");

      // R7: input changes without tick leave corr and freq unchanged
      begin
         longint c0, f0;
         c0 = corr_out; f0 = freq_word;
         @(negedge clk);
         fill_count = 12'd4000; loop_gain = 8'd255;
         repeat (10) @(negedge clk);
         check(longint'(corr_out) == c0, "R7 hold corr", corr_out, c0);
         check(longint'(freq_word) == f0, "R7 hold freq", freq_word, f0);
      end

      // R8: underrun with a large error
      do_tick(4000, 0, 255, 4, 100000, 64'h2000_0000, 1, "R8 override");
      do_tick(100, 100, 5, 4, 100000, 64'h2000_0000, 0, "R8 restart");
      do_tick(110, 100, 16, 4, 100000, 64'h2000_0000, 0, "R8 after");

      // R3: clamp
      do_tick(0, 0, 0, 4, 50, 64'h2000_0000, 1, "R3 clear");
      for (int i = 0; i < 40; i++)
         do_tick(4000, 0, 255, 4, 50, 64'h2000_0000, 0, "R3 clamp");
      check(corr_out <= 50 && corr_out > 0, "R3 bound", corr_out, 50);
      for (int i = 0; i < 10; i++)
         do_tick(0, 4000, 255, 4, 50, 64'h2000_0000, 0, "R3 clamp neg");

      // R5: shift clamping
      do_tick(0, 0, 0, 4, 0, 64'h2000_0000, 1, "R5 clear");
      do_tick(110, 100, 16, 0, 100000, 64'h2000_0000, 0, "R5 low");
      do_tick(0, 0, 0, 4, 0, 64'h2000_0000, 1, "R5 clear2");
      do_tick(1100, 100, 255, 31, 8000000, 64'h2000_0000, 0, "R5 high");

      // R6: saturation at both ends
      do_tick(0, 0, 0, 4, 0, 64'hFFFF_FFF0, 1, "R6 clear");
      do_tick(1100, 100, 100, 4, 100000, 64'hFFFF_FFF0, 0, "R6 top");
      do_tick(0, 0, 0, 4, 0, 3, 1, "R6 clear2");
      do_tick(100, 1100, 100, 4, 100000, 3, 0, "R6 bottom");

      // R9: output rate
      count_rises(64'h1000_0000, 4, "R9 rate 2^28");
      count_rises(64'h2000_0000, 8, "R9 rate 2^29");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule